// File: doc/BRIEF.md
# Chip-Select General Output Unit

This block holds a small bank of general-purpose output lines, eight by default, that a serial host controller can use as chip selects. Software writes a control word that tags each line as a chip select and chooses whether the line's pin is inverted. Software then moves the stored level of any line through a write-only force word. That word has one group of set bits and one group of clear bits, so any subset of lines can be raised or lowered in a single write without a read-modify-write. A status word returns the stored levels.

In normal use a line is held in the set state while idle. To select a device, software writes that line's clear bit. To release the device, it writes the line's set bit. With the inversion bit left at 0 the select is active-low. With the inversion bit at 1 the pin follows the opposite sense and the select is active-high. Reset leaves every line in the set state with no inversion and no chip-select tags.

Top module: `csGpoUnit`

## Requirements
- R1: After reset the stored levels are all 1, every pin is 1, the chip-select tags are all 0 and the control word reads 0.
- R2: A write to address 0 stores the control word. Bits NUM_OUT+n are the chip-select tag of line n and drive `csMark[n]`. Bits n are the inversion select of line n. The word reads back at address 0 from the next cycle.
- R3: A write to address 1 with bit NUM_OUT+n at 1 and bit n at 0 sets the stored level of line n to 1 from the next cycle.
- R4: A write to address 1 with bit n at 1 and bit NUM_OUT+n at 0 clears the stored level of line n to 0 from the next cycle.
- R5: In a write to address 1, a line whose set bit and clear bit are both 1, or both 0, keeps its stored level.
- R6: Pin n is the stored level of line n XOR the inversion select of line n.
- R7: A read of address 2 returns the stored levels before inversion in bits NUM_OUT-1:0, with zeros above them.
- R8: Address 1 reads as 0. Writes to address 2 or 3 change neither the control word nor the stored levels.
- R9: When `wrEn` is 0, no register changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select: 0 control, 1 force, 2 status, 3 unused |
| wrData | input | 2*NUM_OUT | Write data |
| rdData | output | 2*NUM_OUT | Combinational read data for `addr` |
| pinLevel | output | NUM_OUT | Output line levels after inversion |
| csMark | output | NUM_OUT | Chip-select tag of each line |

## Verification
The per-line assertions assume that `wrData` and `addr` are steady at the rising edge on which `wrEn` is sampled, and that writes take effect on that edge with no queuing. The bench changes every input only on the falling clock edge, so each write is seen whole on exactly one rising edge. The stimulus mixes directed words with pseudo-random ones. Those words include set/clear collisions, idle writes with `wrEn` at 0, and writes to the read-only addresses, so the hold property is exercised alongside the set and clear properties.

// File: rtl/csGpoPkg.sv
package csGpoPkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_FORCE = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_RSVD  = 2'd3
  } csAddr_e;

  typedef struct packed {
    logic ctrlWe;
    logic forceWe;
  } csStrobe_t;

endpackage

// File: rtl/csGpoCtrl.sv
module csGpoCtrl
  import csGpoPkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] addr,
  output csStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (addr)
        ADDR_CTRL:  strobe.ctrlWe  = 1'b1;
        ADDR_FORCE: strobe.forceWe = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/csGpoData.sv
module csGpoData
  import csGpoPkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  csStrobe_t              strobe,
  input  logic [1:0]             addr,
  input  logic [2*NUM_OUT-1:0]   wrData,
  output logic [2*NUM_OUT-1:0]   rdData,
  output logic [NUM_OUT-1:0]     pinLevel,
  output logic [NUM_OUT-1:0]     csMark
);

  localparam int DATA_W  = 2 * NUM_OUT;
  localparam int SET_OFS = NUM_OUT;

  logic [DATA_W-1:0]  ctrlReg;
  logic [NUM_OUT-1:0] store;
  logic [NUM_OUT-1:0] invSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (strobe.ctrlWe) ctrlReg <= wrData;
  end

  assign invSel = ctrlReg[NUM_OUT-1:0];
  assign csMark = ctrlReg[DATA_W-1:SET_OFS];

  // ctrl_stable_R9: the control word moves only on its own strobe
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ctrlWe |=> $stable(ctrlReg));

  for (genvar n = 0; n < NUM_OUT; n++) begin : gLine
    logic setReq;
    logic clrReq;
    assign setReq = strobe.forceWe && wrData[SET_OFS+n];
    assign clrReq = strobe.forceWe && wrData[n];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) store[n] <= 1'b1;
      else if (setReq && !clrReq) store[n] <= 1'b1;
      else if (clrReq && !setReq) store[n] <= 1'b0;
    end

    assign pinLevel[n] = store[n] ^ invSel[n];

    assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.forceWe && wrData[SET_OFS+n] && !wrData[n]) |=> store[n]);

    assert_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.forceWe && wrData[n] && !wrData[SET_OFS+n]) |=> !store[n]);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.forceWe && (wrData[n] ^ wrData[SET_OFS+n])) |=> $stable(store[n]));
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = ctrlReg;
      ADDR_STAT: rdData = {{(DATA_W-NUM_OUT){1'b0}}, store};
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/csGpoUnit.sv
module csGpoUnit
  import csGpoPkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           addr,
  input  logic [2*NUM_OUT-1:0] wrData,
  output logic [2*NUM_OUT-1:0] rdData,
  output logic [NUM_OUT-1:0]   pinLevel,
  output logic [NUM_OUT-1:0]   csMark
);

  csStrobe_t strobe;

  csGpoCtrl uCtrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  csGpoData #(.NUM_OUT(NUM_OUT)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .pinLevel (pinLevel),
    .csMark   (csMark)
  );

endmodule

// File: tb/sim_csGpoUnit.sv
`timescale 1ns/1ps
module sim_csGpoUnit;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [15:0]  wrData = '0;
  logic [15:0]  rdData;
  logic [7:0]   pinLevel;
  logic [7:0]   csMark;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] mStore = 8'hFF;
  logic [7:0] mInv   = 8'h00;
  logic [7:0] mCs    = 8'h00;

  always #10 clk = ~clk;

  csGpoUnit #(.NUM_OUT(N)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinLevel(pinLevel), .csMark(csMark)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStore <= 8'hFF; mInv <= 8'h00; mCs <= 8'h00;
    end else if (wrEn && addr == 2'd0) begin
      mCs  <= wrData[15:8];
      mInv <= wrData[7:0];
    end else if (wrEn && addr == 2'd1) begin
      for (int n = 0; n < N; n++) begin
        if (wrData[8+n] && !wrData[n]) mStore[n] <= 1'b1;
        else if (wrData[n] && !wrData[8+n]) mStore[n] <= 1'b0;
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare all outputs at the falling edge, then drive the next input set
  task automatic step(input logic en, input logic [1:0] a, input logic [15:0] d, input string req);
    logic [15:0] expRd;
    @(negedge clk);
    case (addr)
      2'd0:    expRd = {mCs, mInv};
      2'd2:    expRd = {8'h00, mStore};
      default: expRd = 16'h0000;
    endcase
    chk(rdData, expRd, req);
    chk({8'h00, pinLevel}, {8'h00, mStore ^ mInv}, "R6");
    chk({8'h00, csMark}, {8'h00, mCs}, "R2");
    wrEn = en; addr = a; wrData = d;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, control word reads 0, status all ones
    step(0, 2'd0, 16'h0000, "R1");
    step(0, 2'd2, 16'h0000, "R1");
    step(1, 2'd0, 16'h0F00, "R1");
    step(0, 2'd0, 16'h0000, "R2");
    step(1, 2'd1, 16'h0001, "R2");
    step(0, 2'd2, 16'h0000, "R4");
    step(1, 2'd1, 16'h0102, "R7");
    step(0, 2'd2, 16'h0000, "R3");
    step(1, 2'd1, 16'h0404, "R7");
    step(0, 2'd2, 16'h0000, "R5");
    step(0, 2'd1, 16'h00FF, "R5");
    step(0, 2'd0, 16'h55AA, "R9");
    step(1, 2'd3, 16'h00FF, "R9");
    step(1, 2'd2, 16'h1234, "R8");
    step(0, 2'd1, 16'h0000, "R8");
    step(0, 2'd2, 16'h0000, "R8");
    step(1, 2'd0, 16'h0F05, "R8");
    step(1, 2'd1, 16'h00FF, "R2");
    step(1, 2'd1, 16'hFF00, "R4");
    step(1, 2'd1, 16'hA55A, "R3");
    step(1, 2'd1, 16'h3C3C, "R7");
    step(0, 2'd2, 16'h0000, "R5");
    step(0, 2'd0, 16'h0000, "R7");
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[3:2], {lfsr[7:0], lfsr[15:8]}, "R5");
    end
    step(0, 2'd2, 16'h0000, "R7");
    step(0, 2'd0, 16'h0000, "R7");
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule